// File: doc/BRIEF.md
# Flash Security Access Guard

This block decides whether an access to the on-chip code flash may go ahead. Four kinds of requester share it: a parallel programmer port, an in-system programming port, in-application calls made by running code, and the CPU's own instruction path. Each request carries an access mode, an operation, a target address, the bit to program for a protection-bit write, and a flag that says whether the requesting instruction was itself fetched from external code memory. The guard answers with grant or deny and forwards granted requests to the flash controller.

Three protection bits are held in the guard: write lock, read lock and external-execution lock. They are loaded from non-volatile storage in a single boot cycle after reset. Protection applies only to the programmer and in-system modes. In-application requests are exempt, and they alone may query the bits. A table read that was issued from external code and targets internal flash is refused whatever the bits hold.

A small state machine sequences the block. After reset it is in BOOT, where it loads the bits. BOOT always moves to READY on the next edge. READY moves to DECIDE when a strobe is present and otherwise stays in READY. DECIDE presents the verdict for the request it has registered. From DECIDE the machine stays in DECIDE if another strobe arrives, which gives back-to-back requests, and returns to READY if none does.

Top module: `flash_guard`

## Requirements
- R1: After reset the guard spends exactly one cycle in BOOT. In that cycle it copies `nv_sec` into its protection bits (bit 0 write lock, bit 1 read lock, bit 2 external-execution lock) and ignores any strobe, so no verdict follows it.
- R2: A strobe accepted at a clock edge outside BOOT produces exactly one of `grant` or `deny`, high for the whole next cycle and never both. With no accepted strobe, both stay low. Mode codes: 0 programmer, 1 in-system, 2 in-application, 3 CPU. Operation codes: 0 read, 1 program, 2 page erase, 3 chip erase, 4 protection-bit program, 5 protection query, 6 instruction fetch, 7 table read.
- R3: In programmer and in-system modes with the write lock set, program and page erase are denied, while chip erase and protection-bit program are still granted.
- R4: In programmer and in-system modes with the read lock set, read is denied.
- R5: In CPU mode an instruction fetch from an address at or above `INT_BYTES` is denied when the external-execution lock is set. Fetches below `INT_BYTES` are always granted.
- R6: In in-application mode, read, program, page erase, chip erase and protection-bit program are granted whatever the bits hold. Fetch and table read are denied in this mode.
- R7: A protection query is granted only in in-application mode. It returns the three bits in `rdata[2:0]` with the upper bits zero, in the bit order of R1. In other modes it is denied.
- R8: In CPU mode only fetch (6) and table read (7) are accepted. A table read with `req_ext`=1 and an address below `INT_BYTES` is always denied. Any other table read is granted.
- R9: A granted chip erase clears all three bits. A granted protection-bit program sets the bit chosen by `req_bitsel` (0 write, 1 read, 2 external) and never clears one. `req_bitsel`=3 is denied. Every bit change takes effect from the next decision.
- R10: On a deny, `rdata` is 8'hFF and `fl_req` stays low, so the flash is left unchanged. On a grant, `fl_req` is high for every operation except the query. A granted read, fetch or table read returns `fl_rdata`, and any other granted operation except the query returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nv_sec | input | 3 | Stored protection bits, loaded during BOOT |
| req_vld | input | 1 | Request strobe |
| req_mode | input | 2 | Access mode code |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Target address |
| req_ext | input | 1 | Requesting instruction came from external code |
| req_bitsel | input | 2 | Protection bit to program |
| req_wdata | input | DATA_W | Program data |
| grant | output | 1 | Request allowed (cycle after strobe) |
| deny | output | 1 | Request refused, one-cycle violation pulse |
| rdata | output | DATA_W | Data returned to requester |
| fl_req | output | 1 | Forwarded request to flash controller |
| fl_op | output | 3 | Forwarded operation code |
| fl_addr | output | ADDR_W | Forwarded address |
| fl_wdata | output | DATA_W | Forwarded program data |
| fl_rdata | input | DATA_W | Read data from flash controller |

## Verification
The hardest case to reach is a table read that is refused while all three protection bits are clear. To get there, the bench first sets every bit through protection-bit programs made in locked modes. It confirms the bits with in-application queries, clears them with a chip erase that must succeed under the write lock, and only then issues the externally originated table read. A second reset with a non-zero `nv_sec` exercises the boot load. A strobe held during the BOOT cycle shows that the request is dropped.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int SEC_N = 3;
    localparam int SB_WR = 0;
    localparam int SB_RD = 1;
    localparam int SB_XE = 2;

    typedef enum logic [1:0] {
        MD_PAR = 2'd0,
        MD_ISP = 2'd1,
        MD_IAP = 2'd2,
        MD_CPU = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_PROG    = 3'd1,
        OP_PERASE  = 3'd2,
        OP_CERASE  = 3'd3,
        OP_SECPROG = 3'd4,
        OP_SECQRY  = 3'd5,
        OP_IFETCH  = 3'd6,
        OP_TBLRD   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_READY  = 2'd1,
        ST_DECIDE = 2'd2
    } st_e;

endpackage

// File: rtl/guard_fsm.sv
module guard_fsm
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [1:0]        req_mode,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ext,
    input  logic [1:0]        req_bitsel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              boot,
    output logic              q_vld,
    output mode_e             q_mode,
    output op_e               q_op,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_ext,
    output logic [1:0]        q_bitsel,
    output logic [DATA_W-1:0] q_wdata
);

    st_e  state, state_nx;
    logic accept;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:   state_nx = ST_READY;
            ST_READY:  state_nx = req_vld ? ST_DECIDE : ST_READY;
            ST_DECIDE: state_nx = req_vld ? ST_DECIDE : ST_READY;
            default:   state_nx = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_nx;
    end

    // outputs of the machine
    always_comb begin
        boot   = (state == ST_BOOT);
        q_vld  = (state == ST_DECIDE);
        accept = req_vld && (state != ST_BOOT);
    end

    // request register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_mode   <= MD_PAR;
            q_op     <= OP_READ;
            q_addr   <= '0;
            q_ext    <= 1'b0;
            q_bitsel <= 2'd0;
            q_wdata  <= '0;
        end else if (accept) begin
            q_mode   <= mode_e'(req_mode);
            q_op     <= op_e'(req_op);
            q_addr   <= req_addr;
            q_ext    <= req_ext;
            q_bitsel <= req_bitsel;
            q_wdata  <= req_wdata;
        end
    end

    AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |=> (state == ST_READY));                    // R1
    AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && state != ST_BOOT) |=> q_vld);                         // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_vld || state == ST_BOOT) |=> !q_vld);                       // R2

endmodule

// File: rtl/guard_secreg.sv
module guard_secreg
    import flash_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_N-1:0] nv_sec,
    input  logic             set_en,
    input  logic [1:0]       set_idx,
    input  logic             clr_en,
    output logic [SEC_N-1:0] bits
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (load) begin
            bits <= nv_sec;
        end else if (clr_en) begin
            bits <= '0;
        end else if (set_en && (int'(set_idx) < SEC_N)) begin
            bits[set_idx] <= 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < SEC_N; i++) begin : g_sticky
            AST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (bits[i] && !clr_en && !load) |=> bits[i]);               // R9
        end
    endgenerate

    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !load) |=> (bits == '0));                              // R9
    AST_BOOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bits == $past(nv_sec)));                                // R1

endmodule

// File: rtl/guard_policy.sv
module guard_policy
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int INT_BYTES = 16384
) (
    input  logic              vld,
    input  mode_e             mode,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext,
    input  logic [1:0]        bitsel,
    input  logic [SEC_N-1:0]  sec,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              grant,
    output logic              deny,
    output logic [DATA_W-1:0] rdata,
    output logic              fl_req,
    output logic              set_en,
    output logic [1:0]        set_idx,
    output logic              clr_en
);

    localparam logic [ADDR_W-1:0] INT_LIM = ADDR_W'(INT_BYTES);

    logic internal;
    logic allow;
    logic bitsel_ok;
    logic is_rd_path;

    always_comb begin
        internal  = (addr < INT_LIM);
        bitsel_ok = (int'(bitsel) < SEC_N);
        allow     = 1'b0;
        case (mode)
            MD_IAP: begin
                unique case (op)
                    OP_IFETCH, OP_TBLRD: allow = 1'b0;
                    OP_SECPROG:          allow = bitsel_ok;
                    default:             allow = 1'b1;
                endcase
            end
            MD_CPU: begin
                unique case (op)
                    OP_IFETCH: allow = internal || !sec[SB_XE];
                    OP_TBLRD:  allow = !(ext && internal);
                    default:   allow = 1'b0;
                endcase
            end
            default: begin
                unique case (op)
                    OP_READ:            allow = !sec[SB_RD];
                    OP_PROG, OP_PERASE: allow = !sec[SB_WR];
                    OP_CERASE:          allow = 1'b1;
                    OP_SECPROG:         allow = bitsel_ok;
                    default:            allow = 1'b0;
                endcase
            end
        endcase
    end

    always_comb begin
        grant      = vld && allow;
        deny       = vld && !allow;
        is_rd_path = (op == OP_READ) || (op == OP_IFETCH) || (op == OP_TBLRD);
        if (deny)
            rdata = '1;
        else if (grant && is_rd_path)
            rdata = fl_rdata;
        else if (grant && op == OP_SECQRY)
            rdata = {{(DATA_W-SEC_N){1'b0}}, sec};
        else
            rdata = '0;
        fl_req  = grant && (op != OP_SECQRY);
        set_en  = grant && (op == OP_SECPROG);
        set_idx = bitsel;
        clr_en  = grant && (op == OP_CERASE);
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int INT_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        nv_sec,
    input  logic              req_vld,
    input  logic [1:0]        req_mode,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ext,
    input  logic [1:0]        req_bitsel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              grant,
    output logic              deny,
    output logic [DATA_W-1:0] rdata,
    output logic              fl_req,
    output logic [2:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata
);

    localparam logic [ADDR_W-1:0] INT_LIM = ADDR_W'(INT_BYTES);

    logic              boot;
    logic              q_vld;
    mode_e             q_mode;
    op_e               q_op;
    logic [ADDR_W-1:0] q_addr;
    logic              q_ext;
    logic [1:0]        q_bitsel;
    logic [DATA_W-1:0] q_wdata;
    logic [SEC_N-1:0]  sec_bits;
    logic              set_en;
    logic [1:0]        set_idx;
    logic              clr_en;

    guard_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld    (req_vld),
        .req_mode   (req_mode),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_ext    (req_ext),
        .req_bitsel (req_bitsel),
        .req_wdata  (req_wdata),
        .boot       (boot),
        .q_vld      (q_vld),
        .q_mode     (q_mode),
        .q_op       (q_op),
        .q_addr     (q_addr),
        .q_ext      (q_ext),
        .q_bitsel   (q_bitsel),
        .q_wdata    (q_wdata)
    );

    guard_secreg u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (boot),
        .nv_sec  (nv_sec),
        .set_en  (set_en),
        .set_idx (set_idx),
        .clr_en  (clr_en),
        .bits    (sec_bits)
    );

    guard_policy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_BYTES(INT_BYTES)) u_pol (
        .vld      (q_vld),
        .mode     (q_mode),
        .op       (q_op),
        .addr     (q_addr),
        .ext      (q_ext),
        .bitsel   (q_bitsel),
        .sec      (sec_bits),
        .fl_rdata (fl_rdata),
        .grant    (grant),
        .deny     (deny),
        .rdata    (rdata),
        .fl_req   (fl_req),
        .set_en   (set_en),
        .set_idx  (set_idx),
        .clr_en   (clr_en)
    );

    always_comb begin
        fl_op    = q_op;
        fl_addr  = q_addr;
        fl_wdata = q_wdata;
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));                                                // R2
    AST_DENY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        deny |-> (rdata == '1 && !fl_req));                               // R10
    AST_TBL_EXT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !boot && req_mode == 2'd3 && req_op == 3'd7 && req_ext
         && req_addr < INT_LIM) |=> deny);                                // R8
    AST_IAP_ERASE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !boot && req_mode == 2'd2 && req_op == 3'd2) |=> grant); // R6

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  nv_sec = 3'b000;
    logic        req_vld = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic        req_ext = 1'b0;
    logic [1:0]  req_bitsel = 2'd0;
    logic [7:0]  req_wdata = 8'h0;
    logic        grant, deny, fl_req;
    logic [7:0]  rdata, fl_wdata, fl_rdata;
    logic [2:0]  fl_op;
    logic [15:0] fl_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign fl_rdata = fl_addr[7:0] ^ 8'h5A;

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n), .nv_sec(nv_sec), .req_vld(req_vld),
        .req_mode(req_mode), .req_op(req_op), .req_addr(req_addr),
        .req_ext(req_ext), .req_bitsel(req_bitsel), .req_wdata(req_wdata),
        .grant(grant), .deny(deny), .rdata(rdata), .fl_req(fl_req),
        .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    typedef struct {
        bit        g;
        bit        fr;
        logic [7:0] d;
        string     tag;
    } exp_t;

    exp_t sb[$];

    localparam logic [15:0] A_IN = 16'h0123;
    localparam logic [15:0] A_EX = 16'h8040;
    localparam logic [7:0]  D_IN = 8'h79;
    localparam logic [7:0]  D_EX = 8'h1A;

    // driver: called at a falling edge, returns at the next falling edge
    task automatic issue(input logic [1:0] m, input logic [2:0] o,
                         input logic [15:0] a, input logic e,
                         input logic [1:0] bs, input bit g,
                         input logic [7:0] d, input string tag);
        exp_t x;
        x.g = g;
        x.fr = g && (o != 3'd5);
        x.d = d;
        x.tag = tag;
        sb.push_back(x);
        req_mode = m; req_op = o; req_addr = a; req_ext = e;
        req_bitsel = bs; req_wdata = a[7:0]; req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic chk(input bit ok, input string what, input string act, input string exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a verdict shows
    always @(negedge clk) begin
        if (rst_n && (grant || deny)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 verdict without request", $sformatf("g=%0b d=%0b", grant, deny), "none");
            end else begin
                exp_t x;
                x = sb.pop_front();
                chk(grant == x.g && deny == !x.g && rdata == x.d && fl_req == x.fr,
                    {x.tag, " (R10 data/forward)"},
                    $sformatf("g=%0b d=%0b rdata=%h fl_req=%0b", grant, deny, rdata, fl_req),
                    $sformatf("g=%0b d=%0b rdata=%h fl_req=%0b", x.g, !x.g, x.d, x.fr));
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!grant && !deny && !fl_req, "R2 reset state",
            $sformatf("%0b%0b%0b", grant, deny, fl_req), "000");
        // R1: strobe during BOOT is dropped
        req_mode = 2'd0; req_op = 3'd0; req_addr = A_IN; req_vld = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
        chk(!grant && !deny, "R1 boot strobe ignored",
            $sformatf("g=%0b d=%0b", grant, deny), "g=0 d=0");

        issue(2'd0, 3'd0, A_IN, 0, 0, 1, D_IN,  "R4 par read unlocked");
        issue(2'd0, 3'd1, A_IN, 0, 0, 1, 8'h00, "R3 par prog unlocked");
        @(negedge clk);
        chk(!grant && !deny, "R2 idle after gap", $sformatf("%0b%0b", grant, deny), "00");
        issue(2'd2, 3'd5, A_IN, 0, 0, 1, 8'h00, "R7 query zero");
        issue(2'd3, 3'd6, A_EX, 0, 0, 1, D_EX,  "R5 ext fetch unlocked");
        issue(2'd0, 3'd4, A_IN, 0, 0, 1, 8'h00, "R9 set write lock");
        issue(2'd0, 3'd1, A_IN, 0, 0, 0, 8'hFF, "R3 par prog locked");
        issue(2'd1, 3'd2, A_IN, 0, 0, 0, 8'hFF, "R3 isp page erase locked");
        issue(2'd1, 3'd4, A_IN, 0, 1, 1, 8'h00, "R3 secprog under write lock");
        issue(2'd1, 3'd0, A_IN, 0, 0, 0, 8'hFF, "R4 isp read locked");
        issue(2'd0, 3'd0, A_IN, 0, 0, 0, 8'hFF, "R4 par read locked");
        issue(2'd2, 3'd0, A_IN, 0, 0, 1, D_IN,  "R6 iap read exempt");
        issue(2'd2, 3'd2, A_IN, 0, 0, 1, 8'h00, "R6 iap page erase exempt");
        issue(2'd2, 3'd1, A_IN, 0, 0, 1, 8'h00, "R6 iap prog exempt");
        issue(2'd2, 3'd5, A_IN, 0, 0, 1, 8'h03, "R7 query 011");
        issue(2'd0, 3'd5, A_IN, 0, 0, 0, 8'hFF, "R7 query outside iap");
        issue(2'd0, 3'd4, A_IN, 0, 3, 0, 8'hFF, "R9 bitsel 3 refused");
        issue(2'd2, 3'd6, A_IN, 0, 0, 0, 8'hFF, "R6 iap fetch refused");
        issue(2'd0, 3'd4, A_IN, 0, 2, 1, 8'h00, "R9 set ext lock");
        issue(2'd3, 3'd6, A_EX, 0, 0, 0, 8'hFF, "R5 ext fetch locked");
        issue(2'd3, 3'd6, A_IN, 0, 0, 1, D_IN,  "R5 int fetch locked bits");
        issue(2'd3, 3'd7, A_IN, 1, 0, 0, 8'hFF, "R8 tblrd ext->int locked bits");
        issue(2'd2, 3'd5, A_IN, 0, 0, 1, 8'h07, "R7 query 111");
        issue(2'd0, 3'd3, A_IN, 0, 0, 1, 8'h00, "R3 chip erase under lock");
        issue(2'd2, 3'd5, A_IN, 0, 0, 1, 8'h00, "R9 bits cleared by chip erase");
        issue(2'd3, 3'd7, A_IN, 1, 0, 0, 8'hFF, "R8 tblrd ext->int clear bits");
        issue(2'd3, 3'd7, A_IN, 0, 0, 1, D_IN,  "R8 tblrd int->int");
        issue(2'd3, 3'd7, A_EX, 1, 0, 1, D_EX,  "R8 tblrd ext->ext");
        issue(2'd3, 3'd1, A_IN, 0, 0, 0, 8'hFF, "R8 cpu prog refused");
        issue(2'd0, 3'd1, A_IN, 0, 0, 1, 8'h00, "R9 prog after erase");
        issue(2'd1, 3'd0, A_IN, 0, 0, 1, D_IN,  "R4 isp read after erase");
        @(negedge clk);

        // second boot with stored bits 110
        rst_n = 1'b0;
        nv_sec = 3'b110;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        issue(2'd2, 3'd5, A_IN, 0, 0, 1, 8'h06, "R1 boot load 110");
        issue(2'd0, 3'd0, A_IN, 0, 0, 0, 8'hFF, "R4 read lock from boot");
        issue(2'd0, 3'd1, A_IN, 0, 0, 1, 8'h00, "R3 no write lock from boot");
        issue(2'd3, 3'd6, A_EX, 0, 0, 0, 8'hFF, "R5 ext lock from boot");
        @(negedge clk);

        chk(sb.size() == 0, "R2 all requests answered",
            $sformatf("%0d", sb.size()), "0");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule